// File: doc/BRIEF.md
# Microwire EEPROM Word Controller

This block is the master side of a three-wire serial EEPROM link whose chip select is active high. A host asks for a read or a write of a run of 16-bit words beginning at a word offset. The controller checks the request against the device size, raises the select line, and clocks the device through every command. The opcode field width and the address field width are inputs, so one build serves several device sizes.

On a read, every word gets its own opcode and address phase. Sixteen bits are then shifted in and handed to the host with a valid strobe. A standby cycle follows before the next word. On a write, the run is preceded by an erase/write-enable command and closed by an erase/write-disable command. Both carry an opcode field two bits wider than normal and an address field of zeros two bits narrower. Each written word is taken from the host with a take strobe and shifted out. The controller then polls the device's data-out line until it reads high, within a bounded number of polls.

The serial clock comes from a run-time divider. Every level of the serial clock, and every change of select and data, lasts a programmable number of system cycles. Each request ends with a one-cycle done pulse, and the error output is valid with it.

Top module: `mw_eeprom_ctrl`

## Requirements
- R1: After reset, and whenever no request is active, mw_cs, mw_sk and mw_di are low and done is low.
- R2: A request with count 0, with offset not below 2^addr_bits, or with offset+count above 2^addr_bits ends with done and err high within two cycles of start, and mw_cs does not rise. A request that ends exactly at the last word is accepted.
- R3: For each word of a read, the controller sends the read opcode 6 in op_bits bits, then the word's own address (offset+i) in addr_bits bits, MSB first, with mw_di sampled by the device on rising mw_sk. It then shifts in 16 bits MSB first, sampling mw_do just before each rising mw_sk, and presents them on rdata with a one-cycle rd_valid. Before the next word it runs a standby sequence, which lowers select and clock, raises the clock, then raises select and lowers the clock. A read of N words therefore raises mw_cs N+1 times.
- R4: A write of N words first sends the enable code 0x13 in op_bits+2 bits, then addr_bits-2 zero bits, then standby. For each word it sends the write opcode 5 in op_bits bits, the address offset+i in addr_bits bits and the 16 data bits MSB first, then standby. A one-cycle wd_take marks the word taken from wdata. After the last word it sends the disable code 0x10 in op_bits+2 bits, followed by addr_bits-2 zero bits. mw_cs rises 2N+2 times.
- R5: After each written word, mw_do is sampled with POLL_GAP cycles between samples. A high sample ends the wait with another standby. If MAX_POLLS samples are all low, the request ends with err high and no disable command.
- R6: mw_sk, mw_cs and mw_di change only on divider ticks. Each shift phase lasts exactly half_div+1 cycles.
- R7: Every request ends with mw_cs and mw_di low, followed by one full mw_sk pulse ending low, and exactly one single-cycle done pulse.
- R8: op_bits and addr_bits set the field lengths at run time. A device with a 4-bit opcode field and 8 address bits is read correctly at a high address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, taken while idle |
| cmd_write | input | 1 | 1 = write request, 0 = read request |
| offset | input | AW_MAX | First word address |
| count | input | CW | Number of words |
| op_bits | input | 4 | Opcode field width in bits |
| addr_bits | input | 4 | Address field width in bits (2..AW_MAX) |
| half_div | input | DIV_W | Serial clock half-period minus one, in cycles |
| wdata | input | 16 | Word to write, taken on wd_take |
| wd_take | output | 1 | Pulse: wdata taken for the current word |
| rdata | output | 16 | Word read from the device |
| rd_valid | output | 1 | Pulse: rdata holds a new word |
| done | output | 1 | Pulse: request finished |
| err | output | 1 | Request rejected or write timed out; valid with done |
| mw_cs | output | 1 | Device select, active high |
| mw_sk | output | 1 | Serial clock |
| mw_di | output | 1 | Serial data to the device |
| mw_do | input | 1 | Serial data and ready line from the device |

## Verification
The assertions assume that op_bits, addr_bits, half_div and count are held steady while a request runs, and that addr_bits is at least 2. They also assume that field widths never exceed 16 bits and that start is raised only while the block is idle. The bench sets these inputs between requests, always waits for done before the next start, and keeps op_bits+addr_bits small. Its device model answers only on rising serial clock edges seen at the system clock, so it depends on the data-out line settling before the next sampling phase, which the minimum of two cycles per bit guarantees.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PREP, S_EWEN, S_EPAD, S_OPC, S_ADR, S_DAT,
    S_SBY, S_POLL, S_EWDS, S_DPAD, S_STOP, S_FIN
  } mw_state_e;

  // What follows a standby sequence
  typedef enum logic [1:0] {K_EN, K_RD, K_WR, K_PL} mw_sby_e;

  localparam logic [15:0] OPC_READ  = 16'h0006;
  localparam logic [15:0] OPC_WRITE = 16'h0005;
  localparam logic [15:0] OPC_WEN   = 16'h0013;
  localparam logic [15:0] OPC_WDS   = 16'h0010;

  // Request fits inside a device of 2^adw words and is non-empty
  function automatic logic mw_req_ok(input logic [15:0] off,
                                     input logic [15:0] cnt,
                                     input logic [4:0]  adw);
    logic [16:0] lim;
    lim = 17'd1 << adw;
    return (cnt != 16'd0) && ({1'b0, off} < lim) &&
           (({1'b0, off} + {1'b0, cnt}) <= lim);
  endfunction

  // Left-align a field of len bits into a 16-bit shift register
  function automatic logic [15:0] mw_align(input logic [15:0] val,
                                           input logic [4:0] len);
    return val << (5'd16 - len);
  endfunction

endpackage

// File: rtl/mw_clkgen.sv
module mw_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (half_div != '0) |=> !tick);
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
  import mw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        go,
  input  logic [15:0] val,
  input  logic [4:0]  len,
  input  logic        pin_we,
  input  logic        pin_sk,
  input  logic        pin_di,
  input  logic        do_i,
  output logic        sk_o,
  output logic        di_o,
  output logic        busy,
  output logic        fin,
  output logic [15:0] word_in
);
  logic [15:0] sr;
  logic [4:0]  left;
  logic        ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; left <= '0; ph <= 1'b0; busy <= 1'b0; fin <= 1'b0;
      sk_o <= 1'b0; di_o <= 1'b0; word_in <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        sr      <= mw_align(val, len);
        left    <= len;
        ph      <= 1'b0;
        word_in <= '0;
        if (len == 5'd0) fin  <= 1'b1;
        else             busy <= 1'b1;
      end else if (busy && tick) begin
        if (!ph) begin
          di_o <= sr[15];
          sk_o <= 1'b0;
          ph   <= 1'b1;
        end else begin
          sk_o    <= 1'b1;
          word_in <= {word_in[14:0], do_i};
          sr      <= {sr[14:0], 1'b0};
          left    <= left - 1'b1;
          ph      <= 1'b0;
          if (left == 5'd1) begin
            busy <= 1'b0;
            fin  <= 1'b1;
          end
        end
      end else if (pin_we) begin
        sk_o <= pin_sk;
        di_o <= pin_di;
      end
    end
  end

  a_r6_sk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sk_o) && $stable(di_o));
  a_r3_no_go_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);
endmodule

// File: rtl/mw_eeprom_ctrl.sv
module mw_eeprom_ctrl
  import mw_pkg::*;
#(
  parameter int AW_MAX    = 8,
  parameter int CW        = 8,
  parameter int DIV_W     = 8,
  parameter int POLL_GAP  = 2500,
  parameter int MAX_POLLS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_write,
  input  logic [AW_MAX-1:0] offset,
  input  logic [CW-1:0]     count,
  input  logic [3:0]        op_bits,
  input  logic [3:0]        addr_bits,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [15:0]       wdata,
  output logic              wd_take,
  output logic [15:0]       rdata,
  output logic              rd_valid,
  output logic              done,
  output logic              err,
  output logic              mw_cs,
  output logic              mw_sk,
  output logic              mw_di,
  input  logic              mw_do
);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int PC_W  = $clog2(MAX_POLLS + 1);

  mw_state_e         state;
  mw_sby_e           kind;
  logic              wr_q, cs_q, launched;
  logic [1:0]        st_cnt;
  logic [CW-1:0]     cnt_q, word_i;
  logic [AW_MAX-1:0] cur_addr;
  logic [15:0]       wd_q;
  logic [GAP_W-1:0]  poll_tmr;
  logic [PC_W-1:0]   poll_n;

  logic        tick, fld_go, fld_busy, fld_fin, is_field, last_word;
  logic        pin_we, pin_sk, pin_di, sk_w;
  logic [15:0] fld_val, fld_in;
  logic [4:0]  fld_len;

  assign is_field  = state inside {S_EWEN, S_EPAD, S_OPC, S_ADR, S_DAT, S_EWDS, S_DPAD};
  assign last_word = (word_i == cnt_q - 1'b1);

  mw_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(state != S_IDLE),
    .half_div(half_div), .tick(tick));

  mw_shifter u_sh (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(fld_go), .val(fld_val),
    .len(fld_len), .pin_we(pin_we), .pin_sk(pin_sk), .pin_di(pin_di),
    .do_i(mw_do), .sk_o(sk_w), .di_o(mw_di), .busy(fld_busy),
    .fin(fld_fin), .word_in(fld_in));

  always_comb begin
    fld_val = '0;
    fld_len = '0;
    case (state)
      S_EWEN:         begin fld_val = OPC_WEN; fld_len = {1'b0, op_bits} + 5'd2; end
      S_EWDS:         begin fld_val = OPC_WDS; fld_len = {1'b0, op_bits} + 5'd2; end
      S_EPAD, S_DPAD: fld_len = {1'b0, addr_bits} - 5'd2;
      S_OPC:          begin fld_val = wr_q ? OPC_WRITE : OPC_READ; fld_len = {1'b0, op_bits}; end
      S_ADR:          begin fld_val = 16'(cur_addr); fld_len = {1'b0, addr_bits}; end
      S_DAT:          begin fld_val = wr_q ? wd_q : 16'h0; fld_len = 5'd16; end
      default: ;
    endcase
    fld_go = is_field && !launched;
    pin_we = 1'b0;
    pin_sk = 1'b0;
    pin_di = 1'b0;
    if (tick) begin
      case (state)
        S_PREP: pin_we = (st_cnt == 2'd0);
        S_SBY:  begin pin_we = (st_cnt != 2'd2); pin_sk = (st_cnt == 2'd1); end
        S_STOP: begin
          pin_we = 1'b1;
          pin_sk = (st_cnt == 2'd0) ? sk_w : (st_cnt == 2'd1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_EN; wr_q <= 1'b0; cs_q <= 1'b0;
      launched <= 1'b0; st_cnt <= '0; cnt_q <= '0; word_i <= '0;
      cur_addr <= '0; wd_q <= '0; poll_tmr <= '0; poll_n <= '0;
      wd_take <= 1'b0; rdata <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      wd_take  <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (fld_go) launched <= 1'b1;
      if (is_field && fld_fin) begin
        launched <= 1'b0;
        st_cnt   <= '0;
        case (state)
          S_EWEN: state <= S_EPAD;
          S_EPAD: begin state <= S_SBY; kind <= K_EN; end
          S_OPC:  state <= S_ADR;
          S_ADR:  begin
            state <= S_DAT;
            if (wr_q) begin wd_q <= wdata; wd_take <= 1'b1; end
          end
          S_DAT:  begin
            state <= S_SBY;
            kind  <= wr_q ? K_WR : K_RD;
            if (!wr_q) begin rdata <= fld_in; rd_valid <= 1'b1; end
          end
          S_EWDS: state <= S_DPAD;
          default: state <= S_STOP;
        endcase
      end
      case (state)
        S_IDLE: if (start) begin
          wr_q <= cmd_write; cnt_q <= count; cur_addr <= offset;
          word_i <= '0; st_cnt <= '0;
          if (mw_req_ok(16'(offset), 16'(count), {1'b0, addr_bits})) begin
            err <= 1'b0; state <= S_PREP;
          end else begin
            err <= 1'b1; state <= S_FIN;
          end
        end
        S_PREP: if (tick) begin
          st_cnt <= st_cnt + 1'b1;
          if (st_cnt == 2'd1) begin
            cs_q <= 1'b1;
            state <= wr_q ? S_EWEN : S_OPC;
          end
        end
        S_SBY: if (tick) begin
          st_cnt <= st_cnt + 1'b1;
          if (st_cnt == 2'd0) cs_q <= 1'b0;
          if (st_cnt == 2'd2) cs_q <= 1'b1;
          if (st_cnt == 2'd3) begin
            case (kind)
              K_EN: state <= S_OPC;
              K_WR: begin state <= S_POLL; poll_tmr <= '0; poll_n <= '0; end
              default: begin
                if (last_word) state <= (kind == K_PL) ? S_EWDS : S_STOP;
                else begin
                  state <= S_OPC;
                  word_i <= word_i + 1'b1;
                  cur_addr <= cur_addr + 1'b1;
                end
              end
            endcase
          end
        end
        S_POLL: begin
          if (poll_tmr != '0) poll_tmr <= poll_tmr - 1'b1;
          else if (mw_do) begin state <= S_SBY; kind <= K_PL; st_cnt <= '0; end
          else if (poll_n == PC_W'(MAX_POLLS - 1)) begin
            err <= 1'b1; state <= S_STOP; st_cnt <= '0;
          end else begin
            poll_n <= poll_n + 1'b1;
            poll_tmr <= GAP_W'(POLL_GAP - 1);
          end
        end
        S_STOP: if (tick) begin
          st_cnt <= st_cnt + 1'b1;
          if (st_cnt == 2'd0) cs_q <= 1'b0;
          if (st_cnt == 2'd2) state <= S_FIN;
        end
        S_FIN: begin done <= 1'b1; state <= S_IDLE; end
        default: ;
      endcase
    end
  end

  assign mw_cs = cs_q;
  assign mw_sk = sk_w;

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !mw_cs && !mw_sk && !mw_di);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_cs_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cs_q));
  a_r3_cs_during_field: assert property (@(posedge clk) disable iff (!rst_n)
    fld_busy |-> cs_q);
  a_r5_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL) |-> (poll_n < PC_W'(MAX_POLLS)));
  a_r2_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIN) |-> !cs_q);
endmodule

// File: tb/mw_eeprom_ctrl_tb.sv
module mw_eeprom_ctrl_tb;
  localparam int GAP = 10;
  localparam int MAXP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, cmd_write = 1'b0;
  logic [7:0] offset = '0, count = '0;
  logic [3:0] op_bits = 4'd3, addr_bits = 4'd6;
  logic [7:0] half_div = 8'd1;
  logic [15:0] wdata = '0;
  logic wd_take, rd_valid, done, err, mw_cs, mw_sk, mw_di, mw_do;
  logic [15:0] rdata;

  always #10 clk = ~clk;

  mw_eeprom_ctrl #(.AW_MAX(8), .CW(8), .DIV_W(8), .POLL_GAP(GAP), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_write(cmd_write),
    .offset(offset), .count(count), .op_bits(op_bits), .addr_bits(addr_bits),
    .half_div(half_div), .wdata(wdata), .wd_take(wd_take), .rdata(rdata),
    .rd_valid(rd_valid), .done(done), .err(err), .mw_cs(mw_cs), .mw_sk(mw_sk),
    .mw_di(mw_di), .mw_do(mw_do));

  int vectors = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [15:0] mem [0:255];
  logic sk_d = 1'b0, cs_d = 1'b0;
  int mph = 0, bcnt = 0, busy_cnt = 0, busy_len = 0;
  bit busy_forever = 0, we_en = 0, wpend = 0;
  logic [31:0] hdr = '0;
  logic [15:0] dsr = '0, wsr = '0;
  int waddr = 0;
  int cs_rises = 0, n_rd = 0, n_wr = 0, n_ewen = 0, n_ewds = 0;
  int rd_log [0:7];

  assign mw_do = (mph == 1 && mw_cs) ? dsr[15] : ((busy_forever || busy_cnt > 0) ? 1'b0 : 1'b1);

  always @(posedge clk) begin
    sk_d <= mw_sk;
    cs_d <= mw_cs;
    if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if (mw_cs && !cs_d) begin
      cs_rises <= cs_rises + 1; bcnt <= 0; mph <= 0; hdr <= '0; wpend <= 0;
    end else if (!mw_cs && cs_d) begin
      if (wpend && we_en) begin mem[waddr] <= wsr; busy_cnt <= busy_len; end
      wpend <= 0; mph <= 0;
    end else if (mw_cs && mw_sk && !sk_d) begin
      if (mph == 0) begin
        automatic logic [31:0] h = {hdr[30:0], mw_di};
        automatic int msk = (1 << addr_bits) - 1;
        automatic int op = int'(h >> addr_bits);
        automatic int a = int'(h) & msk;
        hdr <= h;
        bcnt <= bcnt + 1;
        if (bcnt + 1 == op_bits + addr_bits) begin
          if (op == 6) begin
            dsr <= mem[a]; mph <= 1;
            if (n_rd < 8) rd_log[n_rd] <= a;
            n_rd <= n_rd + 1;
          end else if (op == 5) begin
            waddr <= a; mph <= 2; bcnt <= 0; n_wr <= n_wr + 1;
          end else begin
            mph <= 3;
            if ((a >> (addr_bits - 2)) == 3) begin we_en <= 1; n_ewen <= n_ewen + 1; end
            else if (a == 0) begin we_en <= 0; n_ewds <= n_ewds + 1; end
          end
        end
      end else if (mph == 1) begin
        dsr <= {dsr[14:0], 1'b0};
      end else if (mph == 2) begin
        wsr <= {wsr[14:0], mw_di};
        bcnt <= bcnt + 1;
        if (bcnt + 1 == 16) begin mph <= 3; wpend <= 1; end
      end
    end
  end

  // ---------------- host side monitors ----------------
  logic [15:0] rbuf [0:7];
  logic [15:0] wbuf [0:7];
  int rcnt = 0, widx = 0, done_cnt = 0;
  int run = 0, min_run = 1000;
  logic sk_prev = 1'b0;

  always @(negedge clk) begin
    if (rd_valid) begin if (rcnt < 8) rbuf[rcnt] = rdata; rcnt++; end
    if (wd_take) begin widx++; wdata = wbuf[widx & 7]; end
    if (done) done_cnt++;
  end

  always @(posedge clk) begin
    if (mw_sk != sk_prev) begin
      if (run < min_run) min_run = run;
      run = 1;
    end else run++;
    sk_prev = mw_sk;
  end

  function automatic logic [15:0] pat(input int a);
    return {a[7:0] ^ 8'h5A, ~a[7:0]};
  endfunction

  int cycles;
  logic err_seen;

  task automatic run_req(input logic wr, input int off, input int cnt);
    @(negedge clk);
    cmd_write = wr; offset = 8'(off); count = 8'(cnt); start = 1'b1;
    rcnt = 0; widx = 0; wdata = wbuf[0];
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 40000) begin @(negedge clk); cycles++; end
    err_seen = err;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 cs after reset", 32'(mw_cs), 0);
    chk("R1 sk after reset", 32'(mw_sk), 0);
    chk("R1 di after reset", 32'(mw_di), 0);
    chk("R1 done after reset", 32'(done), 0);
  endtask

  task automatic t_reject();
    int c0, d0;
    addr_bits = 4'd6;
    c0 = cs_rises; d0 = done_cnt;
    run_req(1'b0, 3, 0);
    chk("R2 zero count err", 32'(err_seen), 1);
    chk("R2 zero count latency", 32'(cycles <= 2), 1);
    run_req(1'b0, 64, 1);
    chk("R2 offset past end err", 32'(err_seen), 1);
    run_req(1'b1, 60, 5);
    chk("R2 run past end err", 32'(err_seen), 1);
    chk("R2 run past end latency", 32'(cycles <= 2), 1);
    chk("R2 no select activity", 32'(cs_rises - c0), 0);
    chk("R7 one done per rejected request", 32'(done_cnt - d0), 3);
  endtask

  task automatic t_read_multi();
    int c0, r0, d0;
    addr_bits = 4'd6; op_bits = 4'd3;
    c0 = cs_rises; r0 = n_rd; d0 = done_cnt;
    run_req(1'b0, 10, 3);
    chk("R3 read err", 32'(err_seen), 0);
    chk("R3 words delivered", 32'(rcnt), 3);
    for (int i = 0; i < 3; i++) begin
      chk("R3 read data", 32'(rbuf[i]), 32'(pat(10 + i)));
      chk("R3 per-word address", 32'(rd_log[r0 + i]), 32'(10 + i));
    end
    chk("R3 read commands", 32'(n_rd - r0), 3);
    chk("R3 standby between words", 32'(cs_rises - c0), 4);
    chk("R7 pins low at end", {29'b0, mw_cs, mw_sk, mw_di}, 0);
    chk("R7 single done", 32'(done_cnt - d0), 1);
  endtask

  task automatic t_read_edge();
    addr_bits = 4'd6;
    run_req(1'b0, 62, 2);
    chk("R2 last-word request accepted", 32'(err_seen), 0);
    chk("R2 last-word data", 32'(rbuf[1]), 32'(pat(63)));
  endtask

  task automatic t_widths();
    op_bits = 4'd4; addr_bits = 4'd8;
    run_req(1'b0, 200, 1);
    chk("R8 wide fields err", 32'(err_seen), 0);
    chk("R8 wide fields data", 32'(rbuf[0]), 32'(pat(200)));
    op_bits = 4'd3; addr_bits = 4'd6;
  endtask

  task automatic t_write();
    int c0, e0, s0, w0;
    addr_bits = 4'd6; op_bits = 4'd3;
    busy_forever = 0; busy_len = 5 * GAP;
    wbuf[0] = 16'h1234; wbuf[1] = 16'hBEEF; wbuf[2] = 16'h0;
    c0 = cs_rises; e0 = n_ewen; s0 = n_ewds; w0 = n_wr;
    run_req(1'b1, 20, 2);
    chk("R5 write completes without err", 32'(err_seen), 0);
    chk("R4 word 0 stored", 32'(mem[20]), 32'h1234);
    chk("R4 word 1 stored", 32'(mem[21]), 32'hBEEF);
    chk("R4 enable sent", 32'(n_ewen - e0), 1);
    chk("R4 disable sent", 32'(n_ewds - s0), 1);
    chk("R4 write commands", 32'(n_wr - w0), 2);
    chk("R4 device left disabled", 32'(we_en), 0);
    chk("R4 words taken", 32'(widx), 2);
    chk("R4 select rises", 32'(cs_rises - c0), 6);
    run_req(1'b0, 20, 2);
    chk("R4 readback", {rbuf[0], rbuf[1]}, 32'h1234BEEF);
  endtask

  task automatic t_timeout();
    int s0;
    busy_forever = 1;
    s0 = n_ewds;
    wbuf[0] = 16'hCAFE;
    run_req(1'b1, 5, 1);
    chk("R5 timeout err", 32'(err_seen), 1);
    chk("R5 poll window length", 32'(cycles >= MAXP * GAP), 1);
    chk("R5 no disable after timeout", 32'(n_ewds - s0), 0);
    chk("R7 pins low after timeout", {29'b0, mw_cs, mw_sk, mw_di}, 0);
    busy_forever = 0;
  endtask

  task automatic t_div();
    half_div = 8'd1; min_run = 1000;
    run_req(1'b0, 1, 1);
    chk("R6 phase length div1", 32'(min_run), 2);
    half_div = 8'd3; min_run = 1000;
    run_req(1'b0, 2, 1);
    chk("R6 phase length div3", 32'(min_run), 4);
    chk("R6 data with slow clock", 32'(rbuf[0]), 32'(pat(2)));
    half_div = 8'd1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    for (int i = 0; i < 8; i++) begin wbuf[i] = '0; rbuf[i] = '0; rd_log[i] = 0; end
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_reject();
    t_read_multi();
    t_read_edge();
    t_widths();
    t_write();
    t_timeout();
    t_div();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL R7 watchdog: request never finished actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule